// File: doc/BRIEF.md
# DDR Clock-Enable Power State Tracker

This block follows the low-power condition of a DDR SDRAM device as a memory controller drives it. At every rising clock edge it takes the clock-enable level, the command code issued on that edge and a flag that says whether every bank is closed. It compares the clock-enable level with the level it stored at the previous edge, and from that decides whether the device stays awake, enters one of three low-power modes, stays in one, or wakes up. The result is a two-bit mode output.

When the device leaves self refresh, two windows start on the same edge. The first is a short recovery window in which only NOP or deselect is allowed. The second is a longer hold-off during which a read is not allowed, because the device's delay-locked loop is still relocking. Command and clock-enable combinations that have no defined meaning, and commands that break either window, produce a one-cycle violation pulse with a kind code. A controller or a monitor on the command bus uses the block as a protocol guard.

Top module: `ddr_pwr_state_tracker`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset, the block reports mode normal (code 0), `viol` low, `viol_kind` 0, `exit_busy` low and `read_hold` low. Reset counts the previous clock-enable level as high.
- R2: In a low-power mode (code 1 precharge power-down, 2 active power-down, 3 self refresh), an edge where clock enable is low at both the previous and the current edge keeps the mode unchanged. The command code on that edge is ignored and raises no violation.
- R3: In a low-power mode, a low-to-high change of clock enable returns the mode to normal (0). If the command on that edge is not NOP (code 0), `viol` pulses with kind 1.
- R4: In normal mode, a high-to-low change of clock enable with NOP (code 0) enters precharge power-down (1) when `banks_idle` is high, and active power-down (2) when it is low.
- R5: In normal mode, a high-to-low change of clock enable with auto refresh (code 5) and `banks_idle` high enters self refresh (3) with no violation. Any other command on a high-to-low edge (auto refresh with a bank open, or any code other than 0 and 5) still enters power-down: precharge power-down (1) if `banks_idle` is high, active power-down (2) if it is low. It also raises `viol` with kind 1.
- R6: In normal mode, clock enable high at both edges keeps the mode normal for every command code.
- R7: The output after the edge that leaves self refresh has `exit_busy` high. `exit_busy` stays high for exactly `XSR_CYC` cycles, then falls.
- R8: While `exit_busy` is high and clock enable was high at the previous edge, any command other than NOP (code 0) raises `viol` with kind 2. Once the window has ended, the same command raises nothing.
- R9: `read_hold` rises on the same edge as `exit_busy` and stays high for `READ_HOLD` cycles. A read (code 2) on any of the `READ_HOLD` edges after the exit edge raises `viol` with kind 3. A read on the next edge after that raises nothing.
- R10: `viol` is a single-cycle pulse, registered on the edge of the offending command, and `viol_kind` is 0 whenever `viol` is low. When several violations happen on the same edge, kind 1 wins over kind 2, and kind 2 wins over kind 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| cke | input | 1 | Clock-enable level at this edge |
| cmd | input | 3 | Command code: 0 NOP/deselect, 1 activate, 2 read, 3 write, 4 precharge, 5 auto refresh, 6 mode set, 7 burst stop |
| banks_idle | input | 1 | High when every bank is precharged |
| pwr_mode | output | 2 | 0 normal, 1 precharge power-down, 2 active power-down, 3 self refresh |
| viol | output | 1 | One-cycle violation pulse |
| viol_kind | output | 2 | 0 none, 1 illegal clock-enable edge command, 2 recovery-window command, 3 early read |
| exit_busy | output | 1 | Self-refresh exit recovery window is open |
| read_hold | output | 1 | Reads are still held off after a self-refresh exit |

## Verification
The assertions check on every cycle that the mode follows from the clock-enable level:
- the mode stays put while clock enable is held low;
- a rise of clock enable always leads back to normal;
- auto refresh with all banks idle leads into self refresh;
- both windows open on a self-refresh exit;
- a kind-3 pulse always traces back to a read;
- no kind code appears without a pulse.

The following need the bench's scenarios:
- the exact length of each window;
- the edge at which a read stops being flagged;
- the order of precedence between violation kinds;
- the complete sweep of starting mode, clock-enable level, command code and bank state.

// File: rtl/ddr_pst_pkg.sv
package ddr_pst_pkg;

  typedef enum logic [1:0] {
    PM_NORM = 2'd0,
    PM_PPD  = 2'd1,
    PM_APD  = 2'd2,
    PM_SREF = 2'd3
  } pwr_mode_e;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_READ  = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_PRE   = 3'd4,
    CMD_AREF  = 3'd5,
    CMD_MRS   = 3'd6,
    CMD_BST   = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    VK_NONE  = 2'd0,
    VK_EDGE  = 2'd1,
    VK_RECOV = 2'd2,
    VK_READ  = 2'd3
  } viol_kind_e;

endpackage

// File: rtl/ddr_pst_mode_fsm.sv
module ddr_pst_mode_fsm
  import ddr_pst_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cke,
  input  cmd_e      cmd,
  input  logic      banks_idle,
  output pwr_mode_e mode_q,
  output logic      cmd_live,
  output logic      sref_exit,
  output logic      bad_edge
);

  logic      cke_q;
  pwr_mode_e mode_d;
  logic      mode_en;

  // Decide from the pair (clock enable at the previous edge, clock enable now)
  always_comb begin
    mode_d    = mode_q;
    sref_exit = 1'b0;
    bad_edge  = 1'b0;
    unique case ({cke_q, cke})
      2'b10: begin
        if (cmd == CMD_AREF && banks_idle) begin
          mode_d = PM_SREF;
        end else begin
          mode_d   = banks_idle ? PM_PPD : PM_APD;
          bad_edge = (cmd != CMD_NOP);
        end
      end
      2'b01: begin
        mode_d    = PM_NORM;
        sref_exit = (mode_q == PM_SREF);
        bad_edge  = (cmd != CMD_NOP);
      end
      default: begin
        mode_d = mode_q;
      end
    endcase
  end

  assign mode_en  = (mode_d != mode_q);
  assign cmd_live = cke_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q  <= 1'b1;
      mode_q <= PM_NORM;
    end else begin
      cke_q <= cke;
      if (mode_en) begin
        mode_q <= mode_d;
      end
    end
  end

endmodule

// File: rtl/ddr_pst_window_ctr.sv
module ddr_pst_window_ctr #(
  parameter int LIMIT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);

  localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign busy   = (cnt_q != '0);
  assign cnt_en = load | busy;

  always_comb begin
    if (load) begin
      cnt_d = LIM_V;
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ddr_pst_viol.sv
module ddr_pst_viol
  import ddr_pst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cmd_e       cmd,
  input  logic       cmd_live,
  input  logic       bad_edge,
  input  logic       rec_busy,
  input  logic       rd_busy,
  output logic       viol_q,
  output viol_kind_e kind_q
);

  viol_kind_e kind_d;

  // Fixed precedence: edge misuse, then recovery window, then early read
  always_comb begin
    if (bad_edge) begin
      kind_d = VK_EDGE;
    end else if (cmd_live && rec_busy && cmd != CMD_NOP) begin
      kind_d = VK_RECOV;
    end else if (cmd_live && rd_busy && cmd == CMD_READ) begin
      kind_d = VK_READ;
    end else begin
      kind_d = VK_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q <= 1'b0;
      kind_q <= VK_NONE;
    end else begin
      viol_q <= (kind_d != VK_NONE);
      kind_q <= kind_d;
    end
  end

endmodule

// File: rtl/ddr_pwr_state_tracker.sv
module ddr_pwr_state_tracker
  import ddr_pst_pkg::*;
#(
  parameter int XSR_CYC   = 10,
  parameter int READ_HOLD = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic [2:0] cmd,
  input  logic       banks_idle,
  output logic [1:0] pwr_mode,
  output logic       viol,
  output logic [1:0] viol_kind,
  output logic       exit_busy,
  output logic       read_hold
);

  localparam int NWIN = 2;
  localparam int WIN_LIM [NWIN] = '{XSR_CYC, READ_HOLD};

  cmd_e       cmd_t;
  pwr_mode_e  mode_q;
  viol_kind_e kind_q;
  logic       cmd_live;
  logic       sref_exit;
  logic       bad_edge;
  logic [NWIN-1:0] win_busy;

  assign cmd_t = cmd_e'(cmd);

  ddr_pst_mode_fsm fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .cmd        (cmd_t),
    .banks_idle (banks_idle),
    .mode_q     (mode_q),
    .cmd_live   (cmd_live),
    .sref_exit  (sref_exit),
    .bad_edge   (bad_edge)
  );

  // Both windows load on the same self-refresh exit edge
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    ddr_pst_window_ctr #(.LIMIT(WIN_LIM[w])) ctr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (sref_exit),
      .busy  (win_busy[w])
    );
  end

  ddr_pst_viol viol_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd_t),
    .cmd_live (cmd_live),
    .bad_edge (bad_edge),
    .rec_busy (win_busy[0]),
    .rd_busy  (win_busy[1]),
    .viol_q   (viol),
    .kind_q   (kind_q)
  );

  assign pwr_mode  = mode_q;
  assign viol_kind = kind_q;
  assign exit_busy = win_busy[0];
  assign read_hold = win_busy[1];

endmodule

// File: rtl/ddr_pst_checker.sv
module ddr_pst_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic [2:0] cmd,
  input logic       banks_idle,
  input logic [1:0] pwr_mode,
  input logic       viol,
  input logic [1:0] viol_kind,
  input logic       exit_busy,
  input logic       read_hold
);

  localparam logic [1:0] M_NORM = 2'd0;
  localparam logic [1:0] M_SREF = 2'd3;
  localparam logic [2:0] C_READ = 3'd2;
  localparam logic [2:0] C_AREF = 3'd5;

  assert_lp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode != M_NORM && !cke) |=> (pwr_mode == $past(pwr_mode)) && !viol);

  assert_lp_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode != M_NORM && cke) |=> (pwr_mode == M_NORM));

  assert_sref_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == M_NORM && !cke && cmd == C_AREF && banks_idle) |=> (pwr_mode == M_SREF));

  assert_windows_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == M_SREF && cke) |=> (exit_busy && read_hold));

  assert_early_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && viol_kind == 2'd3) |-> ($past(cmd) == C_READ));

  assert_kind_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !viol |-> (viol_kind == 2'd0));

endmodule

bind ddr_pwr_state_tracker ddr_pst_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cke        (cke),
  .cmd        (cmd),
  .banks_idle (banks_idle),
  .pwr_mode   (pwr_mode),
  .viol       (viol),
  .viol_kind  (viol_kind),
  .exit_busy  (exit_busy),
  .read_hold  (read_hold)
);

// File: tb/ddr_pwr_state_tracker_tb_top.sv
`timescale 1ns/1ps
module ddr_pwr_state_tracker_tb_top;

  localparam int XSR = 4;
  localparam int RDH = 200;

  logic       clk;
  logic       rst_n;
  logic       cke;
  logic [2:0] cmd;
  logic       banks_idle;
  logic [1:0] pwr_mode;
  logic       viol;
  logic [1:0] viol_kind;
  logic       exit_busy;
  logic       read_hold;

  int n_vec;
  int n_bad;
  bit done;

  ddr_pwr_state_tracker #(.XSR_CYC(XSR), .READ_HOLD(RDH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .banks_idle(banks_idle),
    .pwr_mode(pwr_mode), .viol(viol), .viol_kind(viol_kind),
    .exit_busy(exit_busy), .read_hold(read_hold)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic [2:0] k, input logic idle);
    @(negedge clk);
    cke = c; cmd = k; banks_idle = idle;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cke = 1'b1; cmd = 3'd0; banks_idle = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Enter self refresh and leave it; returns with the exit edge just applied
  task automatic sref_cycle();
    step(1'b0, 3'd5, 1'b1);
    step(1'b1, 3'd0, 1'b1);
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; cke = 1'b1; cmd = 3'd0; banks_idle = 1'b1;

    // R1 reset state
    do_reset();
    #1;
    chk("R1 mode", pwr_mode, 0);
    chk("R1 viol", viol, 0);
    chk("R1 kind", viol_kind, 0);
    chk("R1 exit_busy", exit_busy, 0);
    chk("R1 read_hold", read_hold, 0);

    // Sweep: start mode x cke x command x bank state (R2 R3 R4 R5 R6)
    for (int sm = 0; sm < 4; sm++) begin
      for (int c = 0; c < 2; c++) begin
        for (int k = 0; k < 8; k++) begin
          for (int id = 0; id < 2; id++) begin
            int em; int ek; int eb;
            do_reset();
            if (sm == 1) step(1'b0, 3'd0, 1'b1);
            if (sm == 2) step(1'b0, 3'd0, 1'b0);
            if (sm == 3) step(1'b0, 3'd5, 1'b1);
            step(c[0], k[2:0], id[0]);
            if (sm == 0) begin
              if (c == 1) begin em = 0; ek = 0; end
              else if (k == 5 && id == 1) begin em = 3; ek = 0; end
              else begin em = (id == 1) ? 1 : 2; ek = (k == 0) ? 0 : 1; end
            end else begin
              if (c == 0) begin em = sm; ek = 0; end
              else begin em = 0; ek = (k == 0) ? 0 : 1; end
            end
            eb = (sm == 3 && c == 1) ? 1 : 0;
            chk(sm == 0 ? (c == 1 ? "R6 mode" : "R4/R5 mode") : (c == 0 ? "R2 mode" : "R3 mode"),
                pwr_mode, em);
            chk(sm == 0 ? "R5 kind" : (c == 0 ? "R2 kind" : "R3 kind"), viol_kind, ek);
            chk("R10 pulse", viol, (ek != 0) ? 1 : 0);
            chk("R7 window after sweep edge", exit_busy, eb);
          end
        end
      end
    end

    // R7 / R8: recovery window length and flagging at its last edge
    do_reset();
    sref_cycle();
    chk("R7 exit_busy at exit", exit_busy, 1);
    chk("R9 read_hold at exit", read_hold, 1);
    for (int i = 1; i < XSR; i++) begin
      step(1'b1, 3'd0, 1'b1);
      chk("R7 exit_busy held", exit_busy, 1);
    end
    step(1'b1, 3'd1, 1'b1);
    chk("R8 act on last window edge", viol_kind, 2);
    chk("R7 exit_busy ended", exit_busy, 0);
    step(1'b1, 3'd0, 1'b1);
    chk("R10 pulse one cycle", viol, 0);

    do_reset();
    sref_cycle();
    for (int i = 1; i <= XSR; i++) step(1'b1, 3'd0, 1'b1);
    step(1'b1, 3'd1, 1'b1);
    chk("R8 act after window", viol, 0);

    // R10 precedence: read inside recovery window reports kind 2
    do_reset();
    sref_cycle();
    step(1'b1, 3'd2, 1'b1);
    chk("R10 read in recovery kind", viol_kind, 2);

    // R10 precedence: bad entry inside recovery window reports kind 1
    do_reset();
    sref_cycle();
    step(1'b0, 3'd1, 1'b1);
    chk("R10 edge over recovery kind", viol_kind, 1);
    chk("R5 mode bad entry", pwr_mode, 1);

    // R9 read hold-off boundary
    do_reset();
    sref_cycle();
    for (int i = 1; i < RDH; i++) step(1'b1, 3'd0, 1'b1);
    chk("R9 read_hold before last edge", read_hold, 1);
    step(1'b1, 3'd2, 1'b1);
    chk("R9 read on last held edge", viol_kind, 3);
    chk("R9 read_hold ended", read_hold, 0);
    step(1'b1, 3'd2, 1'b1);
    chk("R9 read after hold", viol, 0);
    chk("R9 kind after hold", viol_kind, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule